// File: doc/BRIEF.md
# AUX Request Framer and Reply Parser

This block sits between a transaction layer and the serial line coder of a display auxiliary channel. On the request side it accepts a command nibble, a 20-bit target address, a transfer length, a write flag and up to `MAX_LEN` payload bytes. It turns them into a byte stream on a valid/ready handshake. The stream starts with a packed header: the command shares its first byte with the top address nibble. An optional length byte follows the header, then the payload on writes. The total byte count of the frame is published alongside the stream.

On the reply side it is told how many bytes the sink returned and whether the hot-plug line was lost. It then consumes the reply bytes one at a time and decodes the status nibble of the first byte. Only an acknowledged reply lets data through. Data bytes are forwarded in order with an index, and a one-cycle done pulse closes every reply. The done pulse carries the reply code, the number of data bytes delivered and an error flag. The error flag is set for an empty reply, for a lost hot-plug line, and for a data count larger than the length of the last request.

Top module: `aux_frame_builder`

## Requirements
- R1: The first stream byte carries the command in bits 7:4 and address bits 19:16 in bits 3:0. The second byte is address bits 15:8 and the third is address bits 7:0.
- R2: When the request length is nonzero, a fourth byte equal to length minus one follows the address. A zero length sends nothing after the third byte on a read.
- R3: `tx_count` equals 3 for a zero length and 4 otherwise, plus the length on writes. It holds that value until the next request. `tx_last` marks the final byte, and `tx_valid` falls after it is taken.
- R4: On writes, payload bytes follow the header in order: byte i is `req_data[8*i+7:8*i]`. Reads send no payload.
- R5: A byte offered with `tx_ready` low stays on `tx_data` until taken. `req_ready` is low while a frame is in progress, and a request presented then is ignored.
- R6: The reply code is the first reply byte shifted right by 4, so its low nibble has no effect. Code 0 means acknowledge.
- R7: On an acknowledged reply of count N, N-1 data bytes are output with indices 0 to N-2. The done pulse comes one cycle after the last of them. N=1 gives done with zero data bytes and no error.
- R8: A reply count of 0 ends with done and error set and no data bytes.
- R9: A lost hot-plug line at reply start ends with done and error set and no data bytes, whatever the count.
- R10: An acknowledged reply whose data count exceeds the last request length ends with done and error set and no data bytes.
- R11: A reply with a nonzero code ends with done, error clear, the code reported and zero data bytes.
- R12: Reply bytes that arrive while no reply is being parsed are ignored and produce no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Framer idle, request taken |
| req_cmd | input | 4 | Command nibble |
| req_addr | input | 20 | Target address |
| req_len | input | LEN_W | Transfer length, 0 to MAX_LEN |
| req_write | input | 1 | Append payload bytes |
| req_data | input | MAX_LEN*8 | Payload, byte i in bits 8i+7:8i |
| tx_valid | output | 1 | Stream byte valid |
| tx_ready | input | 1 | Stream byte accepted |
| tx_data | output | 8 | Stream byte |
| tx_last | output | 1 | Final byte of the frame |
| tx_count | output | CNT_W | Total bytes of the current or last frame |
| rpl_start | input | 1 | Begin parsing a reply |
| rpl_count | input | CNT_W | Reply byte count including status |
| rpl_hpd_lost | input | 1 | Hot-plug line lost |
| rpl_in_valid | input | 1 | Reply byte present |
| rpl_in_byte | input | 8 | Reply byte |
| rpl_code | output | 4 | Decoded reply code |
| rpl_out_valid | output | 1 | Data byte valid |
| rpl_out_byte | output | 8 | Data byte |
| rpl_out_idx | output | LEN_W | Data byte index |
| rpl_ndata | output | LEN_W | Data bytes delivered, valid with done |
| rpl_done | output | 1 | One-cycle end-of-reply pulse |
| rpl_err | output | 1 | Reply failed, valid with done |

## Verification
A stuck or skipped byte index in the framer shows up in the very frame where it happens. The stream then carries a header byte in a payload slot, repeats a byte under backpressure, or runs past `tx_last`. A scoreboard that knows every expected byte flags this on the first wrong beat. In the parser, a wrong state or a remaining-count error surfaces within one reply. Data then leaks after a failed or non-acknowledged status, the done pulse moves by a cycle, or `rpl_ndata` disagrees with the bytes seen. Stray bytes fed while idle expose a parser that fails to return to idle.

// File: rtl/aux_frame_pkg.sv
package aux_frame_pkg;
    localparam int HDR_BYTES = 3;
    localparam logic [3:0] REPLY_ACK = 4'h0;

    typedef enum logic {
        TX_IDLE,
        TX_SEND
    } tx_state_e;

    typedef enum logic [1:0] {
        RP_IDLE,
        RP_STATUS,
        RP_DATA,
        RP_FINISH
    } rp_state_e;
endpackage

// File: rtl/aux_req_serializer.sv
module aux_req_serializer
    import aux_frame_pkg::*;
#(
    parameter int MAX_LEN = 16,
    localparam int LEN_W = $clog2(MAX_LEN + 1),
    localparam int CNT_W = $clog2(MAX_LEN + HDR_BYTES + 2)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    output logic                 req_ready,
    input  logic [3:0]           req_cmd,
    input  logic [19:0]          req_addr,
    input  logic [LEN_W-1:0]     req_len,
    input  logic                 req_write,
    input  logic [MAX_LEN*8-1:0] req_data,
    output logic                 tx_valid,
    input  logic                 tx_ready,
    output logic [7:0]           tx_data,
    output logic                 tx_last,
    output logic [CNT_W-1:0]     tx_count,
    output logic [LEN_W-1:0]     cur_len
);

    typedef struct packed {
        tx_state_e            st;
        logic [3:0]           cmd;
        logic [19:0]          addr;
        logic [LEN_W-1:0]     len;
        logic                 wr;
        logic [MAX_LEN*8-1:0] pay;
        logic [CNT_W-1:0]     idx;
        logic [CNT_W-1:0]     cnt;
    } ser_t;

    ser_t s_d, s_q;

    logic [CNT_W-1:0]     frame_cnt;
    logic                 at_last;
    logic [CNT_W-1:0]     pay_idx;
    logic [MAX_LEN*8-1:0] pay_shift;
    logic [7:0]           byte_sel;

    // Header bytes, one optional length byte, then payload on writes
    assign frame_cnt = CNT_W'(HDR_BYTES) + CNT_W'(req_len != '0)
                     + (req_write ? CNT_W'(req_len) : '0);
    assign at_last   = (s_q.idx == s_q.cnt - CNT_W'(1));
    assign pay_idx   = s_q.idx - CNT_W'(HDR_BYTES + 1);
    assign pay_shift = s_q.pay >> {pay_idx, 3'b000};

    always_comb begin
        if (s_q.idx == CNT_W'(0))
            byte_sel = {s_q.cmd, s_q.addr[19:16]};
        else if (s_q.idx == CNT_W'(1))
            byte_sel = s_q.addr[15:8];
        else if (s_q.idx == CNT_W'(2))
            byte_sel = s_q.addr[7:0];
        else if (s_q.idx == CNT_W'(HDR_BYTES) && s_q.len != '0)
            byte_sel = 8'(s_q.len - LEN_W'(1));
        else
            byte_sel = pay_shift[7:0];
    end

    always_comb begin
        s_d = s_q;
        if (s_q.st == TX_IDLE) begin
            if (req_valid) begin
                s_d.st   = TX_SEND;
                s_d.cmd  = req_cmd;
                s_d.addr = req_addr;
                s_d.len  = req_len;
                s_d.wr   = req_write;
                s_d.pay  = req_data;
                s_d.idx  = '0;
                s_d.cnt  = frame_cnt;
            end
        end else if (tx_ready) begin
            if (at_last)
                s_d.st = TX_IDLE;
            else
                s_d.idx = s_q.idx + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            s_q <= '0;
        else
            s_q <= s_d;
    end

    assign req_ready = (s_q.st == TX_IDLE);
    assign tx_valid  = (s_q.st == TX_SEND);
    assign tx_last   = (s_q.st == TX_SEND) && at_last;
    assign tx_data   = byte_sel;
    assign tx_count  = s_q.cnt;
    assign cur_len   = s_q.len;

    AST_HDR_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready |=> tx_valid && tx_data == {$past(req_cmd), $past(req_addr[19:16])}); // R1
    AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid && !tx_ready |=> tx_valid && $stable(tx_data)); // R5
    AST_FRAME_END: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid && tx_ready && tx_last |=> !tx_valid); // R3

endmodule

// File: rtl/aux_reply_parser.sv
module aux_reply_parser
    import aux_frame_pkg::*;
#(
    parameter int MAX_LEN = 16,
    localparam int LEN_W = $clog2(MAX_LEN + 1),
    localparam int CNT_W = $clog2(MAX_LEN + HDR_BYTES + 2)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LEN_W-1:0] exp_len,
    input  logic             rpl_start,
    input  logic [CNT_W-1:0] rpl_count,
    input  logic             rpl_hpd_lost,
    input  logic             rpl_in_valid,
    input  logic [7:0]       rpl_in_byte,
    output logic [3:0]       rpl_code,
    output logic             rpl_out_valid,
    output logic [7:0]       rpl_out_byte,
    output logic [LEN_W-1:0] rpl_out_idx,
    output logic [LEN_W-1:0] rpl_ndata,
    output logic             rpl_done,
    output logic             rpl_err
);

    typedef struct packed {
        rp_state_e        st;
        logic [CNT_W-1:0] cnt;
        logic [LEN_W-1:0] left;
        logic [LEN_W-1:0] idx;
        logic [3:0]       code;
        logic [LEN_W-1:0] ndata;
        logic             ov;
        logic [7:0]       ob;
        logic [LEN_W-1:0] oidx;
        logic             done;
        logic             err;
    } par_t;

    par_t p_d, p_q;

    logic [CNT_W-1:0] data_cnt;
    logic [3:0]       status_code;
    logic             too_long;

    assign data_cnt    = p_q.cnt - CNT_W'(1);
    assign status_code = rpl_in_byte[7:4];
    assign too_long    = data_cnt > CNT_W'(exp_len);

    always_comb begin
        p_d      = p_q;
        p_d.ov   = 1'b0;
        p_d.done = 1'b0;
        unique case (p_q.st)
            RP_IDLE: begin
                if (rpl_start) begin
                    p_d.err   = 1'b0;
                    p_d.ndata = '0;
                    p_d.code  = '0;
                    p_d.cnt   = rpl_count;
                    if (rpl_hpd_lost || rpl_count == '0) begin
                        p_d.done = 1'b1;
                        p_d.err  = 1'b1;
                    end else begin
                        p_d.st = RP_STATUS;
                    end
                end
            end
            RP_STATUS: begin
                if (rpl_in_valid) begin
                    p_d.code = status_code;
                    if (status_code != REPLY_ACK) begin
                        p_d.done = 1'b1;
                        p_d.st   = RP_IDLE;
                    end else if (too_long) begin
                        p_d.done = 1'b1;
                        p_d.err  = 1'b1;
                        p_d.st   = RP_IDLE;
                    end else if (data_cnt == '0) begin
                        p_d.done = 1'b1;
                        p_d.st   = RP_IDLE;
                    end else begin
                        p_d.left  = LEN_W'(data_cnt);
                        p_d.ndata = LEN_W'(data_cnt);
                        p_d.idx   = '0;
                        p_d.st    = RP_DATA;
                    end
                end
            end
            RP_DATA: begin
                if (rpl_in_valid) begin
                    p_d.ov   = 1'b1;
                    p_d.ob   = rpl_in_byte;
                    p_d.oidx = p_q.idx;
                    p_d.idx  = p_q.idx + LEN_W'(1);
                    p_d.left = p_q.left - LEN_W'(1);
                    if (p_q.left == LEN_W'(1))
                        p_d.st = RP_FINISH;
                end
            end
            RP_FINISH: begin
                p_d.done = 1'b1;
                p_d.st   = RP_IDLE;
            end
            default: p_d.st = RP_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            p_q <= '0;
        else
            p_q <= p_d;
    end

    assign rpl_code      = p_q.code;
    assign rpl_out_valid = p_q.ov;
    assign rpl_out_byte  = p_q.ob;
    assign rpl_out_idx   = p_q.oidx;
    assign rpl_ndata     = p_q.ndata;
    assign rpl_done      = p_q.done;
    assign rpl_err       = p_q.err;

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        rpl_out_valid |-> rpl_out_idx < exp_len); // R10
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rpl_done |=> !rpl_done); // R7
    AST_DONE_AFTER_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        rpl_done |-> !rpl_out_valid); // R7
    AST_ERR_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        rpl_done && rpl_err |-> rpl_ndata == '0); // R8
    AST_NACK_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        rpl_done && rpl_code != REPLY_ACK |-> rpl_ndata == '0); // R11

endmodule

// File: rtl/aux_frame_builder.sv
module aux_frame_builder
    import aux_frame_pkg::*;
#(
    parameter int MAX_LEN = 16,
    localparam int LEN_W = $clog2(MAX_LEN + 1),
    localparam int CNT_W = $clog2(MAX_LEN + HDR_BYTES + 2)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    output logic                 req_ready,
    input  logic [3:0]           req_cmd,
    input  logic [19:0]          req_addr,
    input  logic [LEN_W-1:0]     req_len,
    input  logic                 req_write,
    input  logic [MAX_LEN*8-1:0] req_data,
    output logic                 tx_valid,
    input  logic                 tx_ready,
    output logic [7:0]           tx_data,
    output logic                 tx_last,
    output logic [CNT_W-1:0]     tx_count,
    input  logic                 rpl_start,
    input  logic [CNT_W-1:0]     rpl_count,
    input  logic                 rpl_hpd_lost,
    input  logic                 rpl_in_valid,
    input  logic [7:0]           rpl_in_byte,
    output logic [3:0]           rpl_code,
    output logic                 rpl_out_valid,
    output logic [7:0]           rpl_out_byte,
    output logic [LEN_W-1:0]     rpl_out_idx,
    output logic [LEN_W-1:0]     rpl_ndata,
    output logic                 rpl_done,
    output logic                 rpl_err
);

    logic [LEN_W-1:0] held_len;

    aux_req_serializer #(.MAX_LEN(MAX_LEN)) ser_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .req_cmd   (req_cmd),
        .req_addr  (req_addr),
        .req_len   (req_len),
        .req_write (req_write),
        .req_data  (req_data),
        .tx_valid  (tx_valid),
        .tx_ready  (tx_ready),
        .tx_data   (tx_data),
        .tx_last   (tx_last),
        .tx_count  (tx_count),
        .cur_len   (held_len)
    );

    aux_reply_parser #(.MAX_LEN(MAX_LEN)) par_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .exp_len       (held_len),
        .rpl_start     (rpl_start),
        .rpl_count     (rpl_count),
        .rpl_hpd_lost  (rpl_hpd_lost),
        .rpl_in_valid  (rpl_in_valid),
        .rpl_in_byte   (rpl_in_byte),
        .rpl_code      (rpl_code),
        .rpl_out_valid (rpl_out_valid),
        .rpl_out_byte  (rpl_out_byte),
        .rpl_out_idx   (rpl_out_idx),
        .rpl_ndata     (rpl_ndata),
        .rpl_done      (rpl_done),
        .rpl_err       (rpl_err)
    );

endmodule

// File: tb/aux_frame_builder_tb.sv
module aux_frame_builder_tb_top;
    localparam int MAX_LEN = 16;
    localparam int LEN_W = $clog2(MAX_LEN + 1);
    localparam int CNT_W = $clog2(MAX_LEN + 3 + 2);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic                 req_valid = 1'b0;
    logic                 req_ready;
    logic [3:0]           req_cmd = '0;
    logic [19:0]          req_addr = '0;
    logic [LEN_W-1:0]     req_len = '0;
    logic                 req_write = 1'b0;
    logic [MAX_LEN*8-1:0] req_data = '0;
    logic                 tx_valid;
    logic                 tx_ready;
    logic [7:0]           tx_data;
    logic                 tx_last;
    logic [CNT_W-1:0]     tx_count;
    logic                 rpl_start = 1'b0;
    logic [CNT_W-1:0]     rpl_count = '0;
    logic                 rpl_hpd_lost = 1'b0;
    logic                 rpl_in_valid = 1'b0;
    logic [7:0]           rpl_in_byte = '0;
    logic [3:0]           rpl_code;
    logic                 rpl_out_valid;
    logic [7:0]           rpl_out_byte;
    logic [LEN_W-1:0]     rpl_out_idx;
    logic [LEN_W-1:0]     rpl_ndata;
    logic                 rpl_done;
    logic                 rpl_err;

    aux_frame_builder #(.MAX_LEN(MAX_LEN)) dut_i (.*);

    int n_checks = 0;
    int n_fail = 0;
    int cyc = 0;
    bit bp_en = 1'b0;
    int exp_cnt = 0;
    int last_len = 0;
    int done_seen = 0;
    int out_seen = 0;
    logic [3:0] got_code;
    logic [LEN_W-1:0] got_nd;
    logic got_err;
    bit hold_pend = 1'b0;
    logic [7:0] hold_byte;

    logic [8:0] exp_tx[$];          // {last, byte}
    logic [LEN_W+7:0] exp_rx[$];    // {idx, byte}

    always @(posedge clk) cyc <= cyc + 1;
    assign tx_ready = !bp_en || (cyc % 3 != 2);

    task automatic chk(input string rq, input string what, input longint act, input longint exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, exp);
        end
    endtask

    // Stream monitor / scoreboard
    always @(negedge clk) if (rst_n) begin
        if (hold_pend) begin
            chk("R5", "byte held under backpressure", {tx_valid, tx_data}, {1'b1, hold_byte});
        end
        hold_pend = tx_valid && !tx_ready;
        hold_byte = tx_data;
        if (tx_valid && tx_ready) begin
            if (exp_tx.size() == 0) begin
                chk("R5", "unexpected stream byte", tx_data, 0);
            end else begin
                logic [8:0] e;
                e = exp_tx.pop_front();
                chk("R1", "stream byte", tx_data, e[7:0]);
                chk("R3", "last flag", tx_last, e[8]);
                chk("R3", "tx_count in frame", tx_count, exp_cnt);
            end
        end
    end

    // Reply monitor
    always @(negedge clk) if (rst_n) begin
        if (rpl_out_valid) begin
            out_seen++;
            if (exp_rx.size() == 0) begin
                chk("R12", "unexpected data byte", rpl_out_byte, 0);
            end else begin
                logic [LEN_W+7:0] e;
                e = exp_rx.pop_front();
                chk("R7", "data idx/byte", {rpl_out_idx, rpl_out_byte}, e);
            end
        end
        if (rpl_done) begin
            done_seen++;
            got_code = rpl_code;
            got_nd   = rpl_ndata;
            got_err  = rpl_err;
        end
    end

    task automatic send_req(input logic [3:0] cmd, input logic [19:0] addr, input int len,
                            input bit wr, input bit bp, input bit poke);
        logic [MAX_LEN*8-1:0] pay;
        int total;
        pay = '0;
        for (int i = 0; i < len; i++) pay[8*i +: 8] = 8'(8'h5A ^ (i * 13));
        total = 3 + ((len != 0) ? 1 : 0) + (wr ? len : 0);
        exp_cnt = total;
        exp_tx.push_back({(total == 1), cmd, addr[19:16]});
        exp_tx.push_back({(total == 2), addr[15:8]});
        exp_tx.push_back({(total == 3), addr[7:0]});
        if (len != 0) exp_tx.push_back({(total == 4), 8'(len - 1)});
        if (wr) for (int i = 0; i < len; i++) exp_tx.push_back({(5 + i == total), pay[8*i +: 8]});
        bp_en = bp;
        @(posedge clk); #1;
        while (!req_ready) begin @(posedge clk); #1; end
        req_valid = 1'b1; req_cmd = cmd; req_addr = addr;
        req_len = LEN_W'(len); req_write = wr; req_data = pay;
        @(posedge clk); #1;
        req_valid = 1'b0;
        if (poke) begin
            // R5: a request while busy must be ignored
            chk("R5", "req_ready low while busy", req_ready, 0);
            req_valid = 1'b1; req_cmd = 4'hF; req_addr = 20'hFFFFF; req_len = LEN_W'(1);
            @(posedge clk); #1;
            req_valid = 1'b0;
        end
        while (exp_tx.size() != 0) begin @(posedge clk); #1; end
        repeat (3) @(posedge clk); #1;
        chk("R3", "tx_valid low after frame", tx_valid, 0);
        chk("R3", "tx_count held", tx_count, total);
        chk("R5", "req_ready after frame", req_ready, 1);
        last_len = len;
        bp_en = 1'b0;
    endtask

    task automatic put_byte(input logic [7:0] b, input int gap);
        rpl_in_valid = 1'b1; rpl_in_byte = b;
        @(posedge clk); #1;
        rpl_in_valid = 1'b0;
        repeat (gap) @(posedge clk); #1;
    endtask

    task automatic reply(input string rq, input int cnt, input bit hpd,
                         input logic [7:0] st, input int ndat, input int gap);
        bit e_err;
        int e_nd;
        bit chk_code;
        e_err = 1'b0; e_nd = 0; chk_code = 1'b0;
        if (hpd || cnt == 0) begin
            e_err = 1'b1;
        end else begin
            chk_code = 1'b1;
            if (st[7:4] == 4'h0) begin
                if (cnt - 1 > last_len) e_err = 1'b1;
                else begin
                    e_nd = cnt - 1;
                    for (int i = 0; i < e_nd; i++)
                        exp_rx.push_back({LEN_W'(i), 8'(8'h30 + i * 7)});
                end
            end
        end
        done_seen = 0;
        out_seen = 0;
        rpl_start = 1'b1; rpl_count = CNT_W'(cnt); rpl_hpd_lost = hpd;
        @(posedge clk); #1;
        rpl_start = 1'b0; rpl_hpd_lost = 1'b0;
        put_byte(st, gap);
        for (int i = 0; i < ndat; i++) put_byte(8'(8'h30 + i * 7), gap);
        repeat (4) @(posedge clk); #1;
        chk(rq, "done pulses", done_seen, 1);
        chk(rq, "error flag", got_err, e_err);
        chk(rq, "data count", got_nd, e_nd);
        chk(rq, "data bytes seen", out_seen, e_nd);
        if (chk_code) chk("R6", "reply code", got_code, st[7:4]);
        chk(rq, "expected data drained", exp_rx.size(), 0);
        exp_rx.delete();
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk("R5", "reset req_ready", req_ready, 1);
        chk("R3", "reset tx_valid", tx_valid, 0);
        chk("R3", "reset tx_count", tx_count, 0);
        chk("R7", "reset done", rpl_done, 0);
        chk("R12", "reset out_valid", rpl_out_valid, 0);

        send_req(4'h9, 20'h12345, 0, 1'b0, 1'b0, 1'b0);  // R1 R2: three-byte read header
        send_req(4'h1, 20'hABCDE, 4, 1'b0, 1'b0, 1'b0);  // R2 R4: length byte, no payload on read
        send_req(4'h8, 20'h00F0F, 3, 1'b1, 1'b0, 1'b0);  // R4: write with payload
        send_req(4'h0, 20'h80000, 0, 1'b1, 1'b0, 1'b0);  // R3: zero-length write
        send_req(4'h4, 20'h5A5A5, 16, 1'b1, 1'b1, 1'b1); // R5 R4: full payload, backpressure, busy poke
        send_req(4'h5, 20'h00321, 4, 1'b0, 1'b1, 1'b0);  // last request length 4

        reply("R7", 5, 1'b0, 8'h0F, 4, 0);   // R6: low nibble ignored, exact-size data
        reply("R7", 4, 1'b0, 8'h00, 3, 2);   // gaps between bytes
        reply("R7", 1, 1'b0, 8'h00, 0, 0);   // status only
        reply("R8", 0, 1'b0, 8'h00, 2, 0);   // empty reply
        reply("R9", 3, 1'b1, 8'h00, 2, 0);   // hot-plug lost
        reply("R10", 6, 1'b0, 8'h00, 5, 0);  // data would overflow
        reply("R11", 3, 1'b0, 8'h10, 2, 0);  // nack
        reply("R11", 5, 1'b0, 8'h25, 4, 1);  // defer

        // R12: stray bytes while idle
        done_seen = 0; out_seen = 0;
        put_byte(8'h00, 0); put_byte(8'h77, 1); put_byte(8'h88, 0);
        repeat (3) @(posedge clk); #1;
        chk("R12", "no output from stray bytes", out_seen, 0);
        chk("R12", "no done from stray bytes", done_seen, 0);

        reply("R7", 3, 1'b0, 8'h03, 2, 0);   // parser recovers after stray bytes

        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule